// File: doc/BRIEF.md
# Fractional-N Divider Sequencer with Compensation

This block is the digital controller for a fractional-N frequency synthesizer. It runs on the VCO-side clock. A loadable integer divider counts out divider cycles of either N or N+1 clocks. The choice between the two is made at every cycle boundary by a fractional accumulator. Each boundary adds the fractional numerator to the accumulator, which wraps at a selectable modulus of 5 or 8. A wrap makes the next divider cycle one clock longer, so the long-run average ratio is N plus the numerator over the modulus.

Each divider boundary also starts a compensation pulse of fixed length. With the pulse the block gives an amplitude code, which is the accumulator residue multiplied by an 8-bit programmable scale. It also passes through a 2-bit pump-ratio field, so that the external current DAC scales the compensation current in the same way as the main pump. A separate speed-up flag for the charge pump is raised by a strobe that follows a register load and is dropped when the strobe falls.

The charge pumps, DACs, phase detector and reference path lie outside the block. They only receive the codes and enables that it drives. All pins are plain control and status levels. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `fracn_seq`

## Requirements
- R1: At each divider boundary the residue `frd` becomes (frd + nf) reduced by the modulus M, where M = 5 when `mod5` = 1 and M = 8 when `mod5` = 0. A numerator at or above M is treated as M-1.
- R2: The divider cycle that begins at a boundary is N+1 clocks long when that boundary's addition reached M, and N clocks long otherwise. `div_plus1` shows that carry for the whole cycle. `div_evt` is high for exactly the first clock of every divider cycle.
- R3: With nf = 2 and modulus 5, starting from reset, the residue seen at successive boundaries is 2, 4, 1, 3, 0, 2.
- R4: `comp_en` goes high in the first clock of a divider cycle and stays high for exactly 128 clocks. `comp_amp` reads 0 whenever `comp_en` is low.
- R5: At each boundary `comp_amp` takes the value frd × fdac, using the new residue and the `fdac` applied at that boundary, and `comp_cp` takes `cp_ratio`. Both hold until the next boundary or until the pulse ends. The checked settings are fdac = 128 with modulus 5 and fdac = 80 with modulus 8.
- R6: When a divider cycle is shorter than 128 clocks, the next boundary restarts the pulse with the new amplitude. `comp_en` then stays high, and pulses never overlap.
- R7: `speedup` rises one clock after `strobe` rises, provided `a_load` has pulsed since the last speed-up (the same clock as the rise counts). It falls one clock after `strobe` goes low. A strobe rise with no load pending leaves `speedup` low.
- R8: New values of `n_div`, `nf`, `mod5` and `fdac` are sampled only at a divider boundary. A change made mid-cycle does not alter the length of the cycle in progress.
- R9: Synchronous reset clears `frd`, the divider counter, `div_evt`, `div_plus1`, `comp_en`, `comp_amp`, `comp_cp` and `speedup`. The first `div_evt` comes one clock after reset is released.
- R10: An `n_div` below 2 is treated as 2, so `div_evt` is never high in two clocks in a row.
- R11: `n_div` is 13 bits wide. A value of 8042 gives cycles of 8042 and 8043 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | VCO-side clock |
| rst | input | 1 | Synchronous active-high reset |
| n_div | input | 13 | Integer divide value N |
| nf | input | 3 | Fractional numerator |
| mod5 | input | 1 | 1: modulus 5, 0: modulus 8 |
| fdac | input | 8 | Compensation scale |
| cp_ratio | input | 2 | Pump-ratio field passed to the compensation DAC |
| a_load | input | 1 | One-clock pulse: divider register was loaded |
| strobe | input | 1 | Register-load strobe |
| div_evt | output | 1 | First clock of each divider cycle |
| div_plus1 | output | 1 | Current divider cycle is N+1 long |
| frd | output | 3 | Accumulator residue |
| comp_en | output | 1 | Compensation pulse enable |
| comp_amp | output | 11 | Compensation amplitude code |
| comp_cp | output | 2 | Pump ratio for the compensation DAC |
| speedup | output | 1 | Charge-pump speed-up flag |

## Verification
The bench sweeps every numerator under both moduli and measures each divider period against an arithmetic model. An off-by-one in the carry compare (treating a sum equal to M as no wrap) would show up as a wrong residue and a cycle one clock short. It changes N and the numerator in the middle of a cycle, which catches a design that applies them at once instead of at the boundary. It counts the pulse length with a long N and checks that `comp_en` stays unbroken with a short N, which exposes counters that are off by one or pulses that fail to restart. It also covers clamping of N and of the numerator, and the case of a strobe with no load pending, which a speed-up flag that ignores the load would wrongly answer.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int MOD_LO = 5;   // small modulus; the large one is 2**FW
  localparam int N_MIN  = 2;   // shortest divider cycle
  typedef enum logic {SEL_MOD_HI = 1'b0, SEL_MOD_LO = 1'b1} mod_sel_e;
endpackage

// File: rtl/fracn_acc.sv
module fracn_acc #(
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          mod5,
  input  logic [FW-1:0] nf,
  output logic [FW-1:0] acc,
  output logic [FW-1:0] acc_nxt,
  output logic          carry
);
  import fracn_pkg::*;

  logic [FW:0] m, nfe, sum, r1, r2;

  always_comb begin
    m     = (mod_sel_e'(mod5) == SEL_MOD_LO) ? (FW+1)'(MOD_LO) : {1'b1, {FW{1'b0}}};
    nfe   = ({1'b0, nf} >= m) ? m - 1'b1 : {1'b0, nf};
    sum   = {1'b0, acc} + nfe;
    carry = (sum >= m);
    r1    = carry ? sum - m : sum;
    // a residue left over from the larger modulus may need a second fold
    r2    = (r1 >= m) ? r1 - m : r1;
    acc_nxt = r2[FW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)       acc <= '0;
    else if (step) acc <= acc_nxt;
  end
endmodule

// File: rtl/fracn_divctr.sv
module fracn_divctr #(
  parameter int NW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] n_in,
  input  logic          plus1,
  output logic          tick,
  output logic          evt,
  output logic          plus1_q
);
  import fracn_pkg::*;

  logic [NW-1:0] cnt, n_eff;
  logic [NW:0]   len_m1;

  always_comb begin
    tick   = (cnt == '0);
    n_eff  = (n_in < NW'(N_MIN)) ? NW'(N_MIN) : n_in;
    len_m1 = {1'b0, n_eff} + {{NW{1'b0}}, plus1} - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      evt     <= 1'b0;
      plus1_q <= 1'b0;
    end else if (tick) begin
      cnt     <= len_m1[NW-1:0];
      evt     <= 1'b1;
      plus1_q <= plus1;
    end else begin
      cnt     <= cnt - 1'b1;
      evt     <= 1'b0;
    end
  end
endmodule

// File: rtl/fracn_comp.sv
module fracn_comp #(
  parameter int AW = 11,
  parameter int CW = 2,
  parameter int PW = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] amp_in,
  input  logic [CW-1:0] cp_in,
  output logic          en,
  output logic [AW-1:0] amp,
  output logic [CW-1:0] cp
);
  localparam int PCW = (PW > 1) ? $clog2(PW) : 1;

  logic [PCW-1:0] pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= 1'b0;
      pc  <= '0;
      amp <= '0;
      cp  <= '0;
    end else if (start) begin
      en  <= 1'b1;
      pc  <= PCW'(PW - 1);
      amp <= amp_in;
      cp  <= cp_in;
    end else if (en) begin
      if (pc == '0) begin
        en  <= 1'b0;
        amp <= '0;
      end else begin
        pc <= pc - 1'b1;
      end
    end
  end
endmodule

// File: rtl/fracn_spdup.sv
module fracn_spdup (
  input  logic clk,
  input  logic rst,
  input  logic a_load,
  input  logic strobe,
  output logic speedup
);
  logic armed, stb_q, fire;

  assign fire = strobe && !stb_q && (armed || a_load);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      stb_q   <= 1'b0;
      speedup <= 1'b0;
    end else begin
      stb_q <= strobe;
      if (!strobe)   speedup <= 1'b0;
      else if (fire) speedup <= 1'b1;
      if (fire)        armed <= 1'b0;
      else if (a_load) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/fracn_seq.sv
module fracn_seq #(
  parameter int NW = 13,
  parameter int FW = 3,
  parameter int DW = 8,
  parameter int CW = 2,
  parameter int PW = 128,
  localparam int AW = FW + DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] n_div,
  input  logic [FW-1:0] nf,
  input  logic          mod5,
  input  logic [DW-1:0] fdac,
  input  logic [CW-1:0] cp_ratio,
  input  logic          a_load,
  input  logic          strobe,
  output logic          div_evt,
  output logic          div_plus1,
  output logic [FW-1:0] frd,
  output logic          comp_en,
  output logic [AW-1:0] comp_amp,
  output logic [CW-1:0] comp_cp,
  output logic          speedup
);
  logic          tick, carry;
  logic [FW-1:0] acc_nxt;
  logic [AW-1:0] amp_in;

  assign amp_in = AW'(acc_nxt) * AW'(fdac);

  fracn_acc #(.FW(FW)) u_acc (
    .clk(clk), .rst(rst), .step(tick), .mod5(mod5), .nf(nf),
    .acc(frd), .acc_nxt(acc_nxt), .carry(carry)
  );

  fracn_divctr #(.NW(NW)) u_div (
    .clk(clk), .rst(rst), .n_in(n_div), .plus1(carry),
    .tick(tick), .evt(div_evt), .plus1_q(div_plus1)
  );

  fracn_comp #(.AW(AW), .CW(CW), .PW(PW)) u_comp (
    .clk(clk), .rst(rst), .start(tick), .amp_in(amp_in), .cp_in(cp_ratio),
    .en(comp_en), .amp(comp_amp), .cp(comp_cp)
  );

  fracn_spdup u_spd (
    .clk(clk), .rst(rst), .a_load(a_load), .strobe(strobe), .speedup(speedup)
  );
endmodule

// File: rtl/fracn_seq_chk.sv
module fracn_seq_chk #(
  parameter int FW = 3,
  parameter int AW = 11,
  parameter int PW = 128
) (
  input logic          clk,
  input logic          rst,
  input logic          mod5,
  input logic          strobe,
  input logic          div_evt,
  input logic [FW-1:0] frd,
  input logic          comp_en,
  input logic [AW-1:0] comp_amp,
  input logic          speedup
);
  localparam int HW = $clog2(PW) + 1;

  logic [HW-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst)          hi_q <= '0;
    else if (div_evt) hi_q <= HW'(1);
    else if (comp_en) hi_q <= hi_q + 1'b1;
    else              hi_q <= '0;
  end

  // R4: the pulse begins with the divider event
  a_r4_start: assert property (@(posedge clk) disable iff (rst) div_evt |-> comp_en);
  // R4: no amplitude outside the pulse
  a_r4_amp_idle: assert property (@(posedge clk) disable iff (rst) !comp_en |-> comp_amp == '0);
  // R4: the pulse never outlasts its length
  a_r4_max_len: assert property (@(posedge clk) disable iff (rst)
    (comp_en && !div_evt) |-> hi_q <= HW'(PW - 1));
  // R4: the pulse ends after its last clock unless a new event restarts it
  a_r4_end: assert property (@(posedge clk) disable iff (rst)
    (comp_en && !div_evt && hi_q == HW'(PW - 1)) |=> (!comp_en || div_evt));
  // R1: modulus 5 keeps an in-range residue in range
  a_r1_range: assert property (@(posedge clk) disable iff (rst)
    (div_evt && mod5 && $past(mod5) && $past(frd) < FW'(5)) |-> frd < FW'(5));
  // R10: events are never back to back
  a_r10_gap: assert property (@(posedge clk) disable iff (rst) div_evt |=> !div_evt);
  // R7: speed-up drops after the strobe falls
  a_r7_drop: assert property (@(posedge clk) disable iff (rst) !strobe |=> !speedup);
  // R7: speed-up rises only behind a high strobe
  a_r7_rise: assert property (@(posedge clk) disable iff (rst) $rose(speedup) |-> $past(strobe));
endmodule

bind fracn_seq fracn_seq_chk #(.FW(FW), .AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .mod5(mod5), .strobe(strobe), .div_evt(div_evt),
  .frd(frd), .comp_en(comp_en), .comp_amp(comp_amp), .speedup(speedup)
);

// File: tb/fracn_seq_test.sv
module fracn_seq_test;
  localparam int NW = 13, FW = 3, DW = 8, CW = 2, PW = 128, AW = FW + DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NW-1:0] n_div = 13'd10;
  logic [FW-1:0] nf = '0;
  logic          mod5 = 1'b0;
  logic [DW-1:0] fdac = '0;
  logic [CW-1:0] cp_ratio = '0;
  logic          a_load = 1'b0;
  logic          strobe = 1'b0;
  logic          div_evt, div_plus1, comp_en, speedup;
  logic [FW-1:0] frd;
  logic [AW-1:0] comp_amp;
  logic [CW-1:0] comp_cp;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  fracn_seq uut (
    .clk(clk), .rst(rst), .n_div(n_div), .nf(nf), .mod5(mod5), .fdac(fdac),
    .cp_ratio(cp_ratio), .a_load(a_load), .strobe(strobe),
    .div_evt(div_evt), .div_plus1(div_plus1), .frd(frd), .comp_en(comp_en),
    .comp_amp(comp_amp), .comp_cp(comp_cp), .speedup(speedup)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic wait_evt(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!div_evt && cyc < 20000);
  endtask

  // runs nev divider events from reset and checks each against the model
  task automatic sweep(input bit m5, input int nfv, input int nv, input int fd,
                       input int cpv, input int nev);
    int m, ne, acc_m, s, prev_len, c, neff;
    bit car;
    mod5 = m5; nf = FW'(nfv); n_div = NW'(nv); fdac = DW'(fd); cp_ratio = CW'(cpv);
    do_reset();
    m = m5 ? 5 : 8;
    ne = (nfv >= m) ? m - 1 : nfv;
    neff = (nv < 2) ? 2 : nv;
    acc_m = 0; prev_len = 0;
    for (int e = 0; e < nev; e++) begin
      wait_evt(c);
      s = acc_m + ne;
      car = (s >= m);
      acc_m = car ? s - m : s;
      if (e == 0) chk(c == 1, "R9 first event", c, 1);
      else        chk(c == prev_len, "R2 period", c, prev_len);
      chk(int'(frd) == acc_m, "R1 residue", int'(frd), acc_m);
      chk(div_plus1 == car, "R2 plus1", int'(div_plus1), int'(car));
      chk(int'(comp_amp) == acc_m * fd, "R5 amplitude", int'(comp_amp), acc_m * fd);
      chk(int'(comp_cp) == cpv, "R5 pump ratio", int'(comp_cp), cpv);
      chk(comp_en == 1'b1, "R4 pulse start", int'(comp_en), 1);
      prev_len = neff + int'(car);
    end
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int c, run;
    int seq [6] = '{2, 4, 1, 3, 0, 2};
    bit ok;

    // R9: state while reset is held
    mod5 = 1'b1; nf = 3'd2; fdac = 8'd128; cp_ratio = 2'd3; strobe = 1'b1; a_load = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk(!div_evt && !div_plus1 && frd == '0, "R9 reset divider", int'(frd), 0);
    chk(!comp_en && comp_amp == '0 && comp_cp == '0, "R9 reset comp", int'(comp_amp), 0);
    chk(!speedup, "R9 reset speedup", int'(speedup), 0);
    strobe = 1'b0; a_load = 1'b0;

    // R1, R2, R5: full numerator sweeps at both recommended scales
    for (int v = 0; v < 7; v++) sweep(1'b1, v, 10, 128, v % 4, 11);
    for (int v = 0; v < 8; v++) sweep(1'b0, v, 13, 80, (v + 1) % 4, 10);

    // R3: step sequence for numerator 2 modulo 5
    mod5 = 1'b1; nf = 3'd2; n_div = 13'd9; fdac = 8'd128;
    do_reset();
    ok = 1'b1;
    for (int e = 0; e < 6; e++) begin
      wait_evt(c);
      if (int'(frd) != seq[e]) ok = 1'b0;
      chk(int'(frd) == seq[e], "R3 sequence step", int'(frd), seq[e]);
    end
    chk(ok, "R3 whole sequence", int'(ok), 1);

    // R10: small N clamps to 2
    sweep(1'b0, 3, 0, 80, 1, 9);
    sweep(1'b0, 5, 1, 80, 2, 9);

    // R11: large 13-bit N
    sweep(1'b1, 2, 8042, 128, 0, 4);

    // R4: pulse length with a long cycle
    mod5 = 1'b0; nf = 3'd1; n_div = 13'd300; fdac = 8'd200;
    do_reset();
    wait_evt(c);
    run = 0;
    while (comp_en && run < 400) begin
      run++;
      @(negedge clk);
    end
    chk(run == PW, "R4 pulse length", run, PW);
    chk(comp_amp == '0, "R4 amplitude idle", int'(comp_amp), 0);

    // R6: short cycles keep the pulse high with fresh amplitudes
    n_div = 13'd20; nf = 3'd3;
    do_reset();
    wait_evt(c);
    ok = 1'b1;
    for (int i = 0; i < 90; i++) begin
      @(negedge clk);
      if (!comp_en) ok = 1'b0;
    end
    chk(ok, "R6 continuous pulse", int'(ok), 1);

    // R8: mid-cycle changes wait for the boundary
    mod5 = 1'b0; nf = 3'd0; n_div = 13'd12; fdac = 8'd80;
    do_reset();
    wait_evt(c);
    n_div = 13'd17; nf = 3'd3;
    wait_evt(c);
    chk(c == 12, "R8 old period kept", c, 12);
    chk(int'(frd) == 3, "R8 new numerator at boundary", int'(frd), 3);
    wait_evt(c);
    chk(c == 17, "R8 new period", c, 17);

    // R7: speed-up flag
    @(negedge clk) strobe = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!speedup, "R7 no load pending", int'(speedup), 0);
    strobe = 1'b0;
    @(negedge clk) a_load = 1'b1;
    @(negedge clk) a_load = 1'b0;
    @(negedge clk) strobe = 1'b1;
    @(negedge clk);
    chk(speedup, "R7 rise after load", int'(speedup), 1);
    @(negedge clk);
    chk(speedup, "R7 held with strobe", int'(speedup), 1);
    strobe = 1'b0;
    @(negedge clk);
    chk(!speedup, "R7 drop with strobe", int'(speedup), 0);
    @(negedge clk) strobe = 1'b1;
    @(negedge clk);
    chk(!speedup, "R7 load consumed", int'(speedup), 0);
    strobe = 1'b0;
    @(negedge clk) begin strobe = 1'b1; a_load = 1'b1; end
    @(negedge clk) a_load = 1'b0;
    chk(speedup, "R7 load with rise", int'(speedup), 1);
    strobe = 1'b0;
    @(negedge clk);

    finish_run();
  end
endmodule